// File: doc/BRIEF.md
# Binary-to-Residue Converter with Modular +2

This block takes a 16-bit unsigned word, marked by a one-cycle valid strobe, and turns it into nine residues, one for each modulus of the fixed set {7, 11, 13, 15, 17, 19, 23, 29, 31}. These moduli are pairwise coprime, and their product, 100,280,245,065, needs 37 bits. Each residue lane then adds the constant 2 modulo its own modulus. No lane carries into any other. The nine incremented residues go to a downstream Chinese-remainder reconstruction stage. The low 16 bits of the reconstructed value equal the input plus 2, modulo 65536.

The conversion does not divide. The input word is split into its upper and lower bytes. Each lane reads (upper·256) mod m and lower mod m from constant tables, which are computed when the design is elaborated. One modular addition then joins the two terms. The pipeline has two register stages, conversion and then increment. Each stage carries a validity bit with its data, and a stage's data registers load only when the valid bit entering that stage is set.

Top module: `rns_inc_conv`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has out_valid at 0 and every residue field of res_o at 0.
- R2: out_valid is high in exactly those cycles that come two clock edges after a cycle with in_valid high.
- R3: When out_valid is high, field k of res_o (bits 5k+4 down to 5k) holds (x + 2) mod m_k. Here x is the word that was on din two edges earlier, and m_k is the k-th entry of 7, 11, 13, 15, 17, 19, 23, 29, 31 (k = 0 is modulus 7, k = 8 is modulus 31).
- R4: After reset, every field k of res_o is always less than m_k.
- R5: The increment wraps per lane. A converted residue of m−1 gives 1, and a residue of m−2 gives 0.
- R6: in_valid may be high on consecutive cycles. Each word then produces its own correct result on consecutive cycles, with no loss and no repetition.
- R7: When no valid sample enters the second stage, res_o holds its previous value, whatever din carries.
- R8: Chinese-remainder reconstruction of res_o has low 16 bits equal to (x + 2) mod 65536. For example, 0x03FE gives 0x0400 and 0xFFFF gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 16 | Unsigned input word |
| in_valid | input | 1 | Qualifies din for one cycle |
| res_o | output | 45 | Nine 5-bit incremented residues, field k at bits 5k+4:5k |
| out_valid | output | 1 | Marks res_o as a new result |

## Verification
A corrupted table entry or a bad modular reduction appears two cycles after the affected word enters. The bench sees it as a residue that differs from (x+2) mod m in one lane only. A wrong reduction can also show as a field value at or above its modulus. Every input word is driven, so every table entry and every wrap case of each lane is exercised. A broken validity chain shows at the very next output edge, as a missing, doubled or shifted out_valid, or as res_o changing while no result is due.

// File: rtl/rns_pkg.sv
package rns_pkg;

    localparam int NUM_CH  = 9;
    localparam int RES_W   = 5;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int TAB_N   = 1 << BYTE_W;
    localparam int SUM_W   = RES_W + 1;
    localparam int INC_STEP = 2;

    function automatic int unsigned ch_mod(input int k);
        case (k)
            0: return 7;
            1: return 11;
            2: return 13;
            3: return 15;
            4: return 17;
            5: return 19;
            6: return 23;
            7: return 29;
            default: return 31;
        endcase
    endfunction

    // Packed table: entry i = (i * scale) mod md
    function automatic logic [TAB_N*RES_W-1:0] build_tab(input int unsigned md,
                                                         input int unsigned scale);
        logic [TAB_N*RES_W-1:0] t;
        t = '0;
        for (int i = 0; i < TAB_N; i++) begin
            t[i*RES_W +: RES_W] = RES_W'((i * scale) % md);
        end
        return t;
    endfunction

    typedef logic [NUM_CH-1:0][RES_W-1:0] res_vec_t;

    typedef struct packed {
        logic     v1;
        res_vec_t r1;
        logic     v2;
        res_vec_t r2;
    } pipe_t;

endpackage

// File: rtl/rns_fwd_lane.sv
module rns_fwd_lane
    import rns_pkg::*;
#(
    parameter int unsigned MOD = 7
) (
    input  logic [BYTE_W-1:0] byte_hi,
    input  logic [BYTE_W-1:0] byte_lo,
    output logic [RES_W-1:0]  res
);
    localparam logic [TAB_N*RES_W-1:0] TAB_HI = build_tab(MOD, TAB_N);
    localparam logic [TAB_N*RES_W-1:0] TAB_LO = build_tab(MOD, 1);
    localparam logic [SUM_W-1:0]       MOD_S  = SUM_W'(MOD);

    logic [RES_W-1:0] term_hi_d;
    logic [RES_W-1:0] term_lo_d;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        term_hi_d = TAB_HI[int'(byte_hi)*RES_W +: RES_W];
        term_lo_d = TAB_LO[int'(byte_lo)*RES_W +: RES_W];
        sum_d     = {1'b0, term_hi_d} + {1'b0, term_lo_d};
        if (sum_d >= MOD_S) begin
            sum_d = sum_d - MOD_S;
        end
        res = sum_d[RES_W-1:0];
    end
endmodule

// File: rtl/rns_inc_lane.sv
module rns_inc_lane
    import rns_pkg::*;
#(
    parameter int unsigned MOD = 7
) (
    input  logic [RES_W-1:0] res_in,
    output logic [RES_W-1:0] res_out
);
    localparam logic [SUM_W-1:0] MOD_S  = SUM_W'(MOD);
    localparam logic [SUM_W-1:0] STEP_S = SUM_W'(INC_STEP);

    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = {1'b0, res_in} + STEP_S;
        if (sum_d >= MOD_S) begin
            sum_d = sum_d - MOD_S;
        end
        res_out = sum_d[RES_W-1:0];
    end
endmodule

// File: rtl/rns_inc_conv.sv
module rns_inc_conv
    import rns_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       din,
    input  logic                    in_valid,
    output logic [NUM_CH*RES_W-1:0] res_o,
    output logic                    out_valid
);
    pipe_t    pipe_d, pipe_q;
    res_vec_t fwd_d;
    res_vec_t inc_d;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        rns_fwd_lane #(.MOD(ch_mod(k))) u_fwd (
            .byte_hi (din[DATA_W-1 -: BYTE_W]),
            .byte_lo (din[BYTE_W-1:0]),
            .res     (fwd_d[k])
        );
        rns_inc_lane #(.MOD(ch_mod(k))) u_inc (
            .res_in  (pipe_q.r1[k]),
            .res_out (inc_d[k])
        );

        // R4: every output field stays below its modulus
        assert_res_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pipe_q.r2[k] < RES_W'(ch_mod(k)));

        // R5: a converted residue of m-1 becomes 1 after the increment
        assert_wrap_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_q.v1 && pipe_q.r1[k] == RES_W'(ch_mod(k) - 1)) |=> (pipe_q.r2[k] == RES_W'(1)));

        // R5: a converted residue of m-2 becomes 0 after the increment
        assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_q.v1 && pipe_q.r1[k] == RES_W'(ch_mod(k) - 2)) |=> (pipe_q.r2[k] == '0));
    end

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.v1 = in_valid;
        if (in_valid) begin
            pipe_d.r1 = fwd_d;
        end
        pipe_d.v2 = pipe_q.v1;
        if (pipe_q.v1) begin
            pipe_d.r2 = inc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign res_o     = pipe_q.r2;
    assign out_valid = pipe_q.v2;

    // R2: a valid input reappears at the output two edges later
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no output pulse without a sample in the first stage
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.v1 |=> !out_valid);

    // R7: without a stage-two sample the output holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.v1 |=> $stable(res_o));

endmodule

// File: tb/rns_inc_conv_bench.sv
module rns_inc_conv_bench;
    import rns_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [DATA_W-1:0]       din = '0;
    logic                    in_valid = 1'b0;
    logic [NUM_CH*RES_W-1:0] res_o;
    logic                    out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    int mods[NUM_CH] = '{7, 11, 13, 15, 17, 19, 23, 29, 31};

    // behavioural reference: queue of words in flight, indexed by age
    int  ref_x[$];
    bit  ref_v[$];
    logic [NUM_CH*RES_W-1:0] last_res;

    always #2.5 clk = ~clk;

    rns_inc_conv u_rns_inc_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .in_valid  (in_valid),
        .res_o     (res_o),
        .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int field(input int k);
        return int'(res_o[k*RES_W +: RES_W]);
    endfunction

    // sample inputs at each edge, compare outputs half a cycle later
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_v = {};
            ref_x = {};
            ref_v.push_back(1'b0); ref_v.push_back(1'b0);
            ref_x.push_back(0);    ref_x.push_back(0);
        end else begin
            ref_v.push_front(in_valid);
            ref_x.push_front(int'(din));
            void'(ref_v.pop_back());
            void'(ref_x.pop_back());
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            bit ev;
            int ex;
            ev = ref_v[1];
            ex = ref_x[1];
            check(out_valid == ev, "R2 out_valid timing", out_valid, ev);
            for (int k = 0; k < NUM_CH; k++) begin
                check(field(k) < mods[k], "R4 field range", field(k), mods[k] - 1);
            end
            if (ev) begin
                for (int k = 0; k < NUM_CH; k++) begin
                    int e;
                    e = (ex + INC_STEP) % mods[k];
                    if ((ex % mods[k]) >= mods[k] - 2)
                        check(field(k) == e, "R5 lane wrap", field(k), e);
                    else
                        check(field(k) == e, "R3/R6 residue", field(k), e);
                end
            end else begin
                check(res_o == last_res, "R7 hold", longint'(res_o), longint'(last_res));
            end
            last_res = res_o;
        end
    end

    task automatic reconstruct_check(input int x);
        int found;
        found = -1;
        for (int y = 0; y < 65538 + 4; y++) begin
            bit m;
            m = 1'b1;
            for (int k = 0; k < NUM_CH; k++) begin
                if ((y % mods[k]) != field(k)) m = 1'b0;
            end
            if (m && found < 0) found = y;
        end
        check((found & 16'hFFFF) == ((x + 2) & 16'hFFFF), "R8 reconstruction",
              found & 16'hFFFF, (x + 2) & 16'hFFFF);
    endtask

    task automatic send_one(input int x);
        @(negedge clk);
        din = DATA_W'(x);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        din = 16'hA5A5;
        @(negedge clk);
        // result became visible after the second edge following the pulse
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(res_o == '0, "R1 reset residues", longint'(res_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        last_res = res_o;
        mon_en = 1'b1;

        // R8: directed reconstruction
        send_one(16'h03FE);
        reconstruct_check(16'h03FE);
        send_one(16'hFFFF);
        reconstruct_check(16'hFFFF);
        send_one(0);
        reconstruct_check(0);

        // R7: idle with changing din
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            din = DATA_W'(i * 4097);
        end

        // R3/R5/R6: every word, back to back
        @(negedge clk);
        for (int x = 0; x < 65536; x++) begin
            din = DATA_W'(x);
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R2/R6: irregular gaps
        for (int i = 0; i < 200; i++) begin
            din = DATA_W'((i * 40503 + 7) & 16'hFFFF);
            in_valid = ((i % 3) != 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset again mid-run
        rst_n = 1'b0;
        mon_en = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid again", out_valid, 0);
        check(res_o == '0, "R1 reset residues again", longint'(res_o), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule